// File: doc/BRIEF.md
# Local/Remote Memory Access Arbiter

This block sits in front of a single-ported local memory that belongs to one processing element. Two parties share that memory. The first is the element's own processor, on the local port. The second is any other element, whose request arrives over the shared inter-element bus on the remote port. The memory takes two cycles from command to read data. Commands can be issued every cycle, so a new access may start while earlier ones are still completing.

The local side always wins a same-cycle contest, so its read latency never changes. Once a remote request has been sampled, the arbiter stops accepting new local commands. It lets any local accesses already in the memory pipeline finish, then issues the single remote access. When that access completes, it pulses the acknowledge. Remote read data comes back in the same cycle as the acknowledge. Remote write data is taken straight from the remote port at issue and is never buffered.

The local command port is a valid/ready stream. A command transfers in a cycle where both `loc_valid` and `loc_ready` are high. While `loc_ready` is low, the requester may hold its command or withdraw it; a withdrawn command leaves no trace. The local response is a fixed-latency valid pulse and cannot be back-pressured. On the remote side, `rem_req` and its address and data are held steady until `rem_ack`. The remote requester drops or changes them in the cycle after the acknowledge.

Top module: `pe_mem_arbiter`

## Requirements
- R1: During and right after reset, `loc_ready` is 1 and `mem_en`, `rem_ack` and `loc_rsp_valid` are 0 when no request is presented.
- R2: A local command that transfers (valid and ready high) drives `mem_en`=1 in the same cycle, with `mem_we`, `mem_addr` and `mem_wdata` equal to the local command fields.
- R3: A local read that transfers in cycle c produces `loc_rsp_valid`=1 in cycle c+2, with `loc_rdata` holding the memory word. This holds for reads issued back to back every cycle. A local write produces no response.
- R4: In the cycle where `rem_req` is first seen high, `loc_ready` stays 1 and a local command still transfers. From the next cycle on, `loc_ready` is 0.
- R5: The remote access is sent to the memory in the first cycle after the sampling cycle in which no local access is in flight. That is cycle r+1 when the pipeline is empty, and r+3 when a local access transferred in the sampling cycle r. No memory command is issued between sampling and remote issue.
- R6: `rem_ack` is a one-cycle pulse two cycles after the remote issue. For a read, `rem_rdata` carries the word in that same cycle. A remote write reaches the memory with the remote port's data and is acknowledged on the same schedule.
- R7: `loc_ready` returns to 1 in the cycle after `rem_ack`. A remote request presented in that cycle is sampled as a fresh request.
- R8: A local command presented while `loc_ready` is 0 and withdrawn before ready returns never reaches the memory, and the addressed word keeps its old value.
- R9: A remote read never raises `loc_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local command valid |
| loc_ready | output | 1 | Local command may transfer |
| loc_we | input | 1 | Local command is a write |
| loc_addr | input | ADDR_W | Local word address |
| loc_wdata | input | DATA_W | Local write word |
| loc_rsp_valid | output | 1 | Local read data valid |
| loc_rdata | output | DATA_W | Local read word |
| rem_req | input | 1 | Remote access requested, held until acknowledge |
| rem_we | input | 1 | Remote access is a write |
| rem_addr | input | ADDR_W | Remote word address |
| rem_wdata | input | DATA_W | Remote write word |
| rem_ack | output | 1 | Remote access complete (one cycle) |
| rem_rdata | output | DATA_W | Remote read word, valid with acknowledge |
| mem_en | output | 1 | Memory command strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_rdata | input | DATA_W | Memory read word, two cycles after command |

## Verification
The bench contests the memory in the exact cycle a remote request first appears. A design that froze the local side one cycle early would lose that local read. One that froze it a cycle late would let an extra command through. While a local read drains, the bench holds a blocked local write on the port, checks for silence on the memory strobe, and later reads the addressed word back. A design that skipped draining would issue the remote access on top of the local one. A design that leaked blocked commands would corrupt the word. The bench also presents a new remote request in the cycle right after an acknowledge, to catch a pending flag that either fails to clear or re-arms from the old request. It streams back-to-back local reads to expose any latency that drifts under load.

// File: rtl/pma_pkg.sv
package pma_pkg;
  // one entry of the memory pipeline tracker
  typedef struct packed {
    logic v;    // an access occupies this stage
    logic rem;  // it belongs to the remote port
    logic rd;   // it is a read
  } pma_slot_t;
endpackage

// File: rtl/pma_track.sv
module pma_track
  import pma_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pma_slot_t issue,
  output pma_slot_t tail,
  output logic      local_busy
);
  pma_slot_t stage [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= issue;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  always_comb begin
    local_busy = 1'b0;
    for (int i = 0; i < LAT; i++)
      if (stage[i].v && !stage[i].rem) local_busy = 1'b1;
  end

  assign tail = stage[LAT-1];
endmodule

// File: rtl/pma_ctrl.sv
module pma_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rem_req,
  input  logic rem_done,
  input  logic local_busy,
  output logic pend_q,
  output logic rem_go
);
  logic issued_q;

  // remote goes once the local pipeline has drained, and only once
  assign rem_go = pend_q && !issued_q && !local_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      issued_q <= 1'b0;
    end else begin
      if (rem_done)     pend_q <= 1'b0;
      else if (rem_req) pend_q <= 1'b1;

      if (rem_go)        issued_q <= 1'b1;
      else if (rem_done) issued_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pma_cmdmux.sv
module pma_cmdmux #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              sel_rem,
  input  logic              loc_we,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  input  logic              rem_we,
  input  logic [ADDR_W-1:0] rem_addr,
  input  logic [DATA_W-1:0] rem_wdata,
  output logic              mem_we_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  always_comb begin
    if (sel_rem) begin
      mem_we_sel = rem_we;
      mem_addr   = rem_addr;
      mem_wdata  = rem_wdata;
    end else begin
      mem_we_sel = loc_we;
      mem_addr   = loc_addr;
      mem_wdata  = loc_wdata;
    end
  end
endmodule

// File: rtl/pe_mem_arbiter.sv
module pe_mem_arbiter
  import pma_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_valid,
  output logic              loc_ready,
  input  logic              loc_we,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic              loc_rsp_valid,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic              rem_req,
  input  logic              rem_we,
  input  logic [ADDR_W-1:0] rem_addr,
  input  logic [DATA_W-1:0] rem_wdata,
  output logic              rem_ack,
  output logic [DATA_W-1:0] rem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic      pend_q, rem_go, loc_fire, local_busy, we_sel;
  pma_slot_t issue, tail;

  assign loc_ready = !pend_q;
  assign loc_fire  = loc_valid && loc_ready;

  pma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rem_req(rem_req), .rem_done(rem_ack),
    .local_busy(local_busy), .pend_q(pend_q), .rem_go(rem_go)
  );

  pma_cmdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .sel_rem(rem_go), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .rem_we(rem_we), .rem_addr(rem_addr), .rem_wdata(rem_wdata),
    .mem_we_sel(we_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign mem_en = loc_fire || rem_go;
  assign mem_we = mem_en && we_sel;

  always_comb begin
    issue.v   = mem_en;
    issue.rem = rem_go;
    issue.rd  = mem_en && !we_sel;
  end

  pma_track #(.LAT(MEM_LAT)) u_track (
    .clk(clk), .rst_n(rst_n), .issue(issue), .tail(tail), .local_busy(local_busy)
  );

  assign loc_rsp_valid = tail.v && !tail.rem && tail.rd;
  assign loc_rdata     = mem_rdata;
  assign rem_ack       = tail.v && tail.rem;
  assign rem_rdata     = mem_rdata;
endmodule

// File: rtl/pma_checker.sv
module pma_checker #(
  parameter int ADDR_W  = 8,
  parameter int MEM_LAT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loc_valid,
  input logic              loc_ready,
  input logic              loc_we,
  input logic              loc_rsp_valid,
  input logic              rem_req,
  input logic              rem_we,
  input logic [ADDR_W-1:0] rem_addr,
  input logic              rem_ack,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [MEM_LAT-1:0] rd_sh;
  always_ff @(posedge clk) begin
    if (!rst_n) rd_sh <= '0;
    else        rd_sh <= {rd_sh[MEM_LAT-2:0], loc_valid && loc_ready && !loc_we};
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rem_req && !rem_ack |=> !loc_ready); // R4
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    rem_ack |=> loc_ready); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rem_ack |=> !rem_ack); // R6
  AST_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rem_ack |-> rem_req); // R6
  AST_LOCAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rsp_valid == rd_sh[MEM_LAT-1]); // R3
  AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && !loc_ready |-> mem_addr == rem_addr && mem_we == rem_we); // R8
  AST_NO_REMOTE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rem_ack |-> !loc_rsp_valid); // R9
endmodule

bind pe_mem_arbiter pma_checker #(.ADDR_W(ADDR_W), .MEM_LAT(MEM_LAT)) u_pma_checker (
  .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_ready(loc_ready),
  .loc_we(loc_we), .loc_rsp_valid(loc_rsp_valid), .rem_req(rem_req),
  .rem_we(rem_we), .rem_addr(rem_addr), .rem_ack(rem_ack), .mem_en(mem_en),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/test_pe_mem_arbiter.sv
module test_pe_mem_arbiter;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_valid = 1'b0, loc_we = 1'b0;
  logic [AW-1:0] loc_addr = '0;
  logic [DW-1:0] loc_wdata = '0;
  logic rem_req = 1'b0, rem_we = 1'b0;
  logic [AW-1:0] rem_addr = '0;
  logic [DW-1:0] rem_wdata = '0;
  logic loc_ready, loc_rsp_valid, rem_ack, mem_en, mem_we;
  logic [DW-1:0] loc_rdata, rem_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pe_mem_arbiter #(.ADDR_W(AW), .DATA_W(DW), .MEM_LAT(2)) i_pe_mem_arbiter (
    .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_ready(loc_ready),
    .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rsp_valid(loc_rsp_valid), .loc_rdata(loc_rdata), .rem_req(rem_req),
    .rem_we(rem_we), .rem_addr(rem_addr), .rem_wdata(rem_wdata),
    .rem_ack(rem_ack), .rem_rdata(rem_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // two-cycle memory model
  logic [DW-1:0] bmem [256];
  logic [AW-1:0] rd_a_q = '0;
  logic [DW-1:0] rdata_q = '0;
  initial for (int i = 0; i < 256; i++) bmem[i] = 16'h1000 + 16'(i);
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      rd_a_q <= mem_addr;
    end
    rdata_q <= bmem[rd_a_q];
  end
  assign mem_rdata = rdata_q;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // advance to the next cycle, inputs may then be driven, outputs sampled after #1
  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic idle_in();
    loc_valid = 0; loc_we = 0; rem_req = 0; rem_we = 0;
  endtask

  task automatic t_reset();
    nxt(); #1;
    chk("R1", "ready", loc_ready, 1);
    chk("R1", "mem_en", mem_en, 0);
    chk("R1", "ack", rem_ack, 0);
    chk("R1", "rsp", loc_rsp_valid, 0);
    rst_n = 1;
    nxt(); #1;
    chk("R1", "ready after reset", loc_ready, 1);
  endtask

  task automatic t_local_rw();
    nxt(); loc_valid = 1; loc_we = 1; loc_addr = 8'h05; loc_wdata = 16'hA5A5; #1;
    chk("R2", "mem_en", mem_en, 1);
    chk("R2", "mem_we", mem_we, 1);
    chk("R2", "mem_addr", mem_addr, 8'h05);
    chk("R2", "mem_wdata", mem_wdata, 16'hA5A5);
    nxt(); loc_we = 0; #1;
    chk("R2", "read cmd we", mem_we, 0);
    nxt(); idle_in(); #1;
    chk("R3", "no rsp for write", loc_rsp_valid, 0);
    nxt(); #1;
    chk("R3", "read rsp valid", loc_rsp_valid, 1);
    chk("R3", "read rsp data", loc_rdata, 16'hA5A5);
  endtask

  task automatic t_stream();
    for (int j = 0; j < 6; j++) begin
      nxt();
      loc_valid = (j < 4); loc_we = 0; loc_addr = 8'(8'h0A + j);
      #1;
      if (j >= 2) begin
        chk("R3", "stream rsp valid", loc_rsp_valid, 1);
        chk("R3", "stream rsp data", loc_rdata, 16'h1000 + 16'(8'h0A + j - 2));
      end
    end
    nxt(); idle_in();
  endtask

  task automatic t_remote_idle();
    nxt(); rem_req = 1; rem_we = 0; rem_addr = 8'h20; #1;   // r
    chk("R4", "ready in sample cycle", loc_ready, 1);
    chk("R5", "no issue in sample cycle", mem_en, 0);
    nxt(); #1;                                             // r+1
    chk("R4", "ready low", loc_ready, 0);
    chk("R5", "remote issue", mem_en, 1);
    chk("R5", "remote addr", mem_addr, 8'h20);
    nxt(); #1;                                             // r+2
    chk("R6", "no early ack", rem_ack, 0);
    nxt(); #1;                                             // r+3
    chk("R6", "ack", rem_ack, 1);
    chk("R6", "remote rdata", rem_rdata, 16'h1020);
    chk("R9", "no local rsp", loc_rsp_valid, 0);
    nxt(); rem_addr = 8'h22; #1;                           // fresh request
    chk("R7", "ready back", loc_ready, 1);
    chk("R6", "ack single", rem_ack, 0);
    nxt(); #1;
    chk("R7", "fresh request sampled", loc_ready, 0);
    chk("R7", "fresh issue addr", mem_addr, 8'h22);
    nxt(); nxt(); #1;
    chk("R7", "fresh ack", rem_ack, 1);
    chk("R7", "fresh rdata", rem_rdata, 16'h1022);
    nxt(); idle_in(); #1;
    chk("R7", "ready after fresh", loc_ready, 1);
  endtask

  task automatic t_drain();
    nxt();                                                 // r
    loc_valid = 1; loc_we = 0; loc_addr = 8'h30;
    rem_req = 1; rem_we = 1; rem_addr = 8'h31; rem_wdata = 16'hBEEF; #1;
    chk("R4", "local wins", mem_en, 1);
    chk("R4", "local addr", mem_addr, 8'h30);
    nxt(); loc_we = 1; loc_addr = 8'h40; loc_wdata = 16'hDEAD; #1; // r+1
    chk("R5", "drain silent 1", mem_en, 0);
    chk("R8", "blocked", loc_ready, 0);
    nxt(); #1;                                             // r+2
    chk("R5", "drain silent 2", mem_en, 0);
    chk("R3", "drained rsp", loc_rsp_valid, 1);
    chk("R3", "drained data", loc_rdata, 16'h1030);
    nxt(); loc_valid = 0; #1;                              // r+3
    chk("R5", "remote issue after drain", mem_en, 1);
    chk("R6", "remote write we", mem_we, 1);
    chk("R6", "remote write data", mem_wdata, 16'hBEEF);
    chk("R5", "remote write addr", mem_addr, 8'h31);
    nxt(); #1;
    chk("R6", "no early ack", rem_ack, 0);
    nxt(); #1;                                             // r+5
    chk("R6", "write ack", rem_ack, 1);
    chk("R9", "no local rsp", loc_rsp_valid, 0);
    nxt(); idle_in(); loc_valid = 1; loc_addr = 8'h31; #1; // r+6
    chk("R7", "ready back", loc_ready, 1);
    nxt(); loc_addr = 8'h40; #1;
    nxt(); loc_valid = 0; #1;
    chk("R6", "remote write landed", loc_rdata, 16'hBEEF);
    nxt(); #1;
    chk("R8", "blocked write ignored", loc_rdata, 16'h1040);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_local_rw();
    t_stream();
    t_remote_idle();
    t_drain();
    nxt(); nxt();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule